// File: doc/BRIEF.md
# Period-Register PWM Generator

This block turns a system clock into one pulse-width-modulated output. The time base has three stages. A prescaler divides the clock by 1, 4 or 16. Below the 8-bit period timer sits a 2-bit phase counter. Together the timer and the phase counter form a 10-bit running count. When the timer equals the period register on the last phase, the count returns to zero. A new period then starts, so one period lasts (period + 1) × 4 × prescale clocks.

The output goes high at the start of each period and drops when the 10-bit count reaches the active duty value. Software programs the duty as an upper byte and a 2-bit low field. These writes land in a shadow copy, which is moved into the active compare register only at a period boundary. Whenever the timer or PWM mode is switched off, the counters rest at zero and the output stays low. A one-clock match pulse marks every period boundary.

Top module: `pwm_gen`

## Requirements
- R1: One PWM period lasts (P+1)·4·N clocks, where P is the period register and N is the prescale divisor. `match_o` is high for exactly one clock at the end of each period, in the first clock of the new period.
- R2: The prescale select field (control bits [1:0]) maps 0 to divide by 1, 1 to divide by 4, and 2 or 3 to divide by 16.
- R3: The output is high in the first clock of every period. It goes low once the 10-bit count {timer, phase} reaches the active duty D, so it stays high for D·N clocks of the period.
- R4: If D ≥ (P+1)·4, the output stays high for the entire period.
- R5: If D = 0, the output stays low for the entire period.
- R6: A duty write made during a period does not change that period. The new value takes effect from the next period start.
- R7: When either the timer-enable bit (control bit 2) or the PWM-enable bit (control bit 3) is 0, the output is low and no match pulse occurs. On re-enable, a new period starts from count zero in the clock after the enabling write.
- R8: After synchronous reset, all registers are zero, the block is disabled, and both outputs are low.
- R9: Writes are decoded by `wr_addr`:
  - 0: period byte
  - 1: duty upper byte (duty bits [9:2])
  - 2: duty low field (`wr_data[1:0]`, duty bits [1:0])
  - 3: control

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pwm_o | output | 1 | PWM output |
| match_o | output | 1 | One-clock period-boundary pulse |

## Verification
The full-duty property assumes the period register is written only while the block is disabled. A period change in mid-run could let the count pass a duty value that was out of range under the old period. The bench follows this rule: it always clears the control register before it loads a new period. Duty writes are the only register writes made while the block is running. They exercise the shadow path and must not disturb the running period. The one-cycle match property relies on every period lasting at least four clocks, which holds for any legal setting.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

    localparam int TMR_W = 8;
    localparam int SUB_W = 2;
    localparam int CNT_W = TMR_W + SUB_W;
    localparam int PRE_W = 4;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV4   = 2'd1,
        PS_DIV16  = 2'd2,
        PS_DIV16B = 2'd3
    } presc_e;

    typedef enum logic [1:0] {
        A_PERIOD  = 2'd0,
        A_DUTY_HI = 2'd1,
        A_DUTY_LO = 2'd2,
        A_CTRL    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [TMR_W-1:0]         period;
        logic [TMR_W-1:0]         duty_hi;
        logic [SUB_W-1:0]         duty_lo;
        presc_e                   presc;
        logic                     tmr_en;
        logic                     pwm_en;
    } cfg_t;

    function automatic logic [PRE_W-1:0] presc_last(presc_e sel);
        case (sel)
            PS_DIV1: presc_last = PRE_W'(0);
            PS_DIV4: presc_last = PRE_W'(3);
            default: presc_last = PRE_W'(15);
        endcase
    endfunction

endpackage

// File: rtl/pwm_gen_regs.sv
module pwm_gen_regs
    import pwm_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    output cfg_t             cfg_o
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_PERIOD:  cfg_q.period  <= wr_data;
                A_DUTY_HI: cfg_q.duty_hi <= wr_data;
                A_DUTY_LO: cfg_q.duty_lo <= wr_data[SUB_W-1:0];
                default: begin
                    cfg_q.presc  <= presc_e'(wr_data[1:0]);
                    cfg_q.tmr_en <= wr_data[2];
                    cfg_q.pwm_en <= wr_data[3];
                end
            endcase
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/pwm_gen_prescaler.sv
module pwm_gen_prescaler
    import pwm_gen_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  presc_e sel,
    output logic   step_o
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;

    assign last   = presc_last(sel);
    assign step_o = run && (pre_q >= last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else if (step_o) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/pwm_gen_timebase.sv
module pwm_gen_timebase
    import pwm_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step,
    input  logic [TMR_W-1:0] period,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             wrap_o,
    output logic             match_o
);
    logic [TMR_W-1:0] tmr_q;
    logic [SUB_W-1:0] sub_q;
    logic             match_q;

    assign cnt_o     = {tmr_q, sub_q};
    assign wrap_o    = run && step && (&sub_q) && (tmr_q == period);
    assign cnt_nxt_o = wrap_o ? '0 : cnt_o + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tmr_q   <= '0;
            sub_q   <= '0;
            match_q <= 1'b0;
        end else begin
            match_q <= wrap_o;
            if (step) begin
                {tmr_q, sub_q} <= cnt_nxt_o;
            end
        end
    end

    assign match_o = match_q;
endmodule

// File: rtl/pwm_gen_compare.sv
module pwm_gen_compare
    import pwm_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] shadow,
    output logic             high_o,
    output logic [CNT_W-1:0] active_o
);
    logic [CNT_W-1:0] active_q;
    logic             high_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
            high_q   <= 1'b0;
        end else if (!run || wrap) begin
            active_q <= shadow;
            high_q   <= (shadow != '0);
        end else if (step && (cnt_nxt == active_q)) begin
            high_q   <= 1'b0;
        end
    end

    assign high_o   = high_q;
    assign active_o = active_q;
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
    import pwm_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    output logic             pwm_o,
    output logic             match_o
);
    cfg_t             cfg;
    logic             run;
    logic             step;
    logic             wrap;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] active_duty;
    logic             high;

    pwm_gen_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_o   (cfg)
    );

    assign run = cfg.tmr_en && cfg.pwm_en;

    pwm_gen_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .sel    (cfg.presc),
        .step_o (step)
    );

    pwm_gen_timebase u_tb (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .step      (step),
        .period    (cfg.period),
        .cnt_o     (cnt),
        .cnt_nxt_o (cnt_nxt),
        .wrap_o    (wrap),
        .match_o   (match_o)
    );

    pwm_gen_compare u_cmp (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .step     (step),
        .wrap     (wrap),
        .cnt_nxt  (cnt_nxt),
        .shadow   ({cfg.duty_hi, cfg.duty_lo}),
        .high_o   (high),
        .active_o (active_duty)
    );

    assign pwm_o = run && high;
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk
    import pwm_gen_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [TMR_W-1:0] wr_data,
    input logic             run,
    input logic             wrap,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] active_duty,
    input logic [TMR_W-1:0] period,
    input logic             pwm_o,
    input logic             match_o
);
    logic [CNT_W:0] span;
    assign span = {1'b0, period, {SUB_W{1'b1}}} + (CNT_W+1)'(1);

    AST_MATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        match_o |=> !match_o); // R1

    AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_o) |-> (cnt == '0)); // R3

    AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
        (match_o && active_duty != '0) |-> pwm_o); // R3

    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (rst)
        (run && {1'b0, active_duty} >= span) |-> pwm_o); // R4

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
        (match_o && active_duty == '0) |-> !pwm_o); // R5

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> $stable(active_duty)); // R6

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd3 && !wr_data[2]) |=> (!pwm_o && !match_o)); // R7
endmodule

bind pwm_gen pwm_gen_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .run         (run),
    .wrap        (wrap),
    .cnt         (cnt),
    .active_duty (active_duty),
    .period      (cfg.period),
    .pwm_o       (pwm_o),
    .match_o     (match_o)
);

// File: tb/pwm_gen_tb_top.sv
module pwm_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_o;
    logic       match_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_gen dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm_o),
        .match_o (match_o)
    );

    // {period[8], duty[10], presc sel[2], period clocks[16], high clocks[16]}
    localparam int NV = 8;
    localparam logic [51:0] VEC [NV] = '{
        {8'd3, 10'd5,    2'd0, 16'd16, 16'd5},
        {8'd3, 10'd16,   2'd0, 16'd16, 16'd16},
        {8'd3, 10'd0,    2'd0, 16'd16, 16'd0},
        {8'd1, 10'd3,    2'd1, 16'd32, 16'd12},
        {8'd0, 10'd2,    2'd2, 16'd64, 16'd32},
        {8'd0, 10'd1,    2'd3, 16'd64, 16'd16},
        {8'd7, 10'd31,   2'd0, 16'd32, 16'd31},
        {8'd7, 10'd1000, 2'd0, 16'd32, 16'd32}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input logic [7:0] p, input logic [9:0] d, input logic [1:0] sel);
        wr(2'd3, 8'h00);
        wr(2'd0, p);
        wr(2'd1, d[9:2]);
        wr(2'd2, {6'd0, d[1:0]});
        wr(2'd3, {4'd0, 1'b1, 1'b1, sel});
    endtask

    // Samples one full period starting at the current negedge (period clock 0)
    task automatic measure(input int len, output int highs, output int early_match);
        highs = 0; early_match = 0;
        for (int j = 0; j < len; j++) begin
            if (pwm_o) highs++;
            if (match_o) early_match++;
            @(negedge clk);
        end
    endtask

    initial begin
        int highs, em;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pwm_o == 1'b0, "R8 pwm after reset", pwm_o, 0);
        chk(match_o == 1'b0, "R8 match after reset", match_o, 0);
        // R8: zeroed registers mean disabled; no activity even with time
        repeat (20) @(negedge clk);
        chk(pwm_o == 1'b0 && match_o == 1'b0, "R8 idle after reset", pwm_o, 0);

        // Table walk: R1 R2 R3 R4 R5 R9
        for (int v = 0; v < NV; v++) begin
            logic [7:0]  p;
            logic [9:0]  d;
            logic [1:0]  sel;
            int len, hexp;
            {p, d, sel} = VEC[v][51:32];
            len  = int'(VEC[v][31:16]);
            hexp = int'(VEC[v][15:0]);
            setup(p, d, sel);
            chk(pwm_o == (d != 0), "R3/R5 level at period start", pwm_o, int'(d != 0));
            measure(len, highs, em);
            chk(highs == hexp, "R3/R4/R5/R2 high clocks per period", highs, hexp);
            chk(em == 0, "R1 no match inside period", em, 0);
            chk(match_o == 1'b1, "R1 match at period end", match_o, 1);
            chk(pwm_o == (d != 0), "R3 level at next period start", pwm_o, int'(d != 0));
            @(negedge clk);
            chk(match_o == 1'b0, "R1 match lasts one clock", match_o, 0);
        end

        // R7: timer on, PWM mode off
        setup(8'd3, 10'd5, 2'd0);
        repeat (3) @(negedge clk);
        wr(2'd3, 8'h04);
        chk(pwm_o == 1'b0, "R7 low with PWM mode off", pwm_o, 0);
        measure(40, highs, em);
        chk(highs == 0 && em == 0, "R7 quiet while disabled", highs + em, 0);
        // R7: restart from count zero
        wr(2'd3, 8'h0C);
        chk(pwm_o == 1'b1, "R7 restart high at count zero", pwm_o, 1);
        measure(16, highs, em);
        chk(highs == 5, "R7 restart period duty", highs, 5);
        chk(match_o == 1'b1, "R7 restart period length", match_o, 1);
        wr(2'd3, 8'h08);
        chk(pwm_o == 1'b0, "R7 low with timer off", pwm_o, 0);

        // R6: duty write mid-period takes effect next period
        setup(8'd7, 10'd8, 2'd0);
        highs = 0;
        for (int j = 0; j < 32; j++) begin
            if (pwm_o) highs++;
            if (j == 0) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd5; end
            if (j == 1) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd0; end
            if (j == 2) wr_en = 1'b0;
            @(negedge clk);
        end
        chk(highs == 8, "R6 current period keeps old duty", highs, 8);
        measure(32, highs, em);
        chk(highs == 20, "R6 next period uses new duty", highs, 20);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule